// File: doc/BRIEF.md
# Interrupt Router Core

This block collects a set of external interrupt request lines and routes them to a set of hart contexts. Each source goes through its own gateway, which can be set to level or edge triggering. A source that the gateway accepts becomes pending. For each context, an arbiter picks the best pending source that the context has enabled and that clears the context's priority threshold. The result drives the context's interrupt line.

Software reaches the block through a simple synchronous register port. Through it, software sets per-source priorities and trigger configuration, per-context enable masks and per-context thresholds. Each context has a claim register. Reading it takes ownership of the winning source and returns that source's ID. Writing the same ID back to it releases the source. In edge mode, each source also has a policy for edges that arrive while it is pending or claimed: the gateway either counts them and replays them after completion, or drops them.

Top module: `irq_router`

## Requirements
- R1: After reset, every priority, configuration, enable mask and threshold reads as 0. Every context line is low, and a claim read returns 0.
- R2: A source can raise a context's line, or be claimed by that context, only when bit s of that context's enable mask (source s) is set.
- R3: A source is eligible for a context only when its priority is nonzero and strictly greater than the context's threshold. A priority equal to the threshold is masked.
- R4: Among eligible sources, the highest priority wins. On equal priority, the lowest source ID wins. The context's line is high exactly when some source is eligible.
- R5: A read of a context's claim register returns the winning source ID, or 0 if none, on the clock after the read. The same read clears that source's pending state.
- R6: A claimed source is not presented again until the claiming context writes its ID to that context's claim register. A completion with an ID that is not claimed, or that comes from a different context, is ignored.
- R7: In level mode (configuration bit 0 = 0), a high input makes an idle source pending. After completion, the source becomes pending again if the input is still high.
- R8: In edge mode (configuration bit 0 = 1), only a 0-to-1 transition of the input makes a source pending. An input held high does not re-trigger after completion.
- R9: In edge queue mode (configuration bit 1 = 1), rising edges seen while the source is pending or claimed are counted, up to EDGE_MAX. Each completion replays one counted edge as a new pending request.
- R10: In edge drop mode (configuration bit 1 = 0), rising edges seen while the source is pending or claimed are discarded.
- R11: The address is split into a group (bits 8:6) and an index (bits 5:0). The groups are: 0 = priority of source index, 1 = configuration of source index, 2 = enable mask of context index (bit s = source s), 3 = threshold of context index, 4 = claim/complete of context index. A written value reads back unchanged one clock after the read. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIrq | input | NUM_SRC | Request lines, bit s is source s |
| regWe | input | 1 | Register write strobe |
| regRe | input | 1 | Register read strobe |
| regAddr | input | 9 | Register address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, registered |
| ctxIrq | output | NUM_CTX | Interrupt line per context |

## Verification
Every result is due a fixed number of clock edges after its stimulus. A context line reflects an input change or a configuration write right after the edge that samples it. Claim and read data appear after the edge that takes the read. A replayed or re-asserted request becomes pending at the second edge after the completion write, so a claim issued on the very next cycle still returns 0. The bench drives each stimulus at the falling edge and advances its reference model at the same rising edge as the design. It compares the context lines and read data at the following falling edge, so every check lands on the cycle in which the result becomes due.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 6;

  typedef enum logic [2:0] {
    KIND_PRIO  = 3'd0,
    KIND_CFG   = 3'd1,
    KIND_EN    = 3'd2,
    KIND_THR   = 3'd3,
    KIND_CLAIM = 3'd4,
    KIND_NONE  = 3'd7
  } regKindE;

  typedef struct packed {
    logic               wrPrio;
    logic               wrCfg;
    logic               wrEn;
    logic               wrThr;
    logic               complete;
    logic               claim;
    logic               rdEn;
    regKindE            rdKind;
    logic [IDX_W-1:0]   idx;
  } ctlStrobeT;
endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int NUM_CTX = 2
) (
  input  logic              regWe,
  input  logic              regRe,
  input  logic [ADDR_W-1:0] regAddr,
  output ctlStrobeT         stb
);
  logic [2:0]       grp;
  logic [IDX_W-1:0] idx;
  logic             srcOk;
  logic             ctxOk;

  always_comb begin
    grp   = regAddr[ADDR_W-1 -: 3];
    idx   = regAddr[IDX_W-1:0];
    srcOk = (idx != '0) && (int'(idx) <= NUM_SRC);
    ctxOk = int'(idx) < NUM_CTX;

    stb        = '0;
    stb.rdKind = KIND_NONE;
    stb.idx    = idx;

    if (regWe) begin
      case (grp)
        3'd0:    stb.wrPrio   = srcOk;
        3'd1:    stb.wrCfg    = srcOk;
        3'd2:    stb.wrEn     = ctxOk;
        3'd3:    stb.wrThr    = ctxOk;
        3'd4:    stb.complete = ctxOk;
        default: ;
      endcase
    end else if (regRe) begin
      stb.rdEn = 1'b1;
      case (grp)
        3'd0: if (srcOk) stb.rdKind = KIND_PRIO;
        3'd1: if (srcOk) stb.rdKind = KIND_CFG;
        3'd2: if (ctxOk) stb.rdKind = KIND_EN;
        3'd3: if (ctxOk) stb.rdKind = KIND_THR;
        3'd4: if (ctxOk) begin
          stb.rdKind = KIND_CLAIM;
          stb.claim  = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_router_gateway.sv
module irq_router_gateway #(
  parameter int EDGE_MAX = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic irqIn,
  input  logic isEdge,
  input  logic queueMode,
  input  logic claimStb,
  input  logic completeStb,
  output logic pending,
  output logic active
);
  localparam int CNT_W = $clog2(EDGE_MAX + 1);

  logic             prevIn;
  logic [CNT_W-1:0] edgeCnt;
  logic             rise;
  logic             idle;
  logic             cntFull;

  assign rise    = irqIn & ~prevIn;
  assign idle    = !active && !pending;
  assign cntFull = edgeCnt == CNT_W'(EDGE_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      active  <= 1'b0;
      prevIn  <= 1'b0;
      edgeCnt <= '0;
    end else begin
      prevIn <= irqIn;
      if (claimStb) begin
        pending <= 1'b0;
        active  <= 1'b1;
      end else if (completeStb && active) begin
        active <= 1'b0;
      end else if (idle) begin
        if (!isEdge) begin
          pending <= irqIn;
        end else if (rise) begin
          pending <= 1'b1;
        end else if (edgeCnt != '0) begin
          pending <= 1'b1;
          edgeCnt <= edgeCnt - 1'b1;
        end
      end
      if (isEdge && queueMode && rise && (active || pending || claimStb) && !cntFull)
        edgeCnt <= edgeCnt + 1'b1;
    end
  end

  AST_CLAIM_TAKES: assert property (@(posedge clk) disable iff (!rstN) claimStb |=> (active && !pending)); // R5
  AST_HOLD_INFLIGHT: assert property (@(posedge clk) disable iff (!rstN) (active && !completeStb) |=> active); // R6
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN) edgeCnt <= CNT_W'(EDGE_MAX)); // R9
  AST_DROP_NO_GROWTH: assert property (@(posedge clk) disable iff (!rstN) !queueMode |=> (edgeCnt <= $past(edgeCnt))); // R10
endmodule

// File: rtl/irq_router_arb.sv
module irq_router_arb #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 4
) (
  input  logic [NUM_SRC:1]        req,
  input  logic [NUM_SRC*PRIO_W-1:0] prioFlat,
  input  logic [PRIO_W-1:0]       thr,
  output logic [ID_W-1:0]         bestId
);
  logic [PRIO_W-1:0] bestPrio;
  logic [PRIO_W-1:0] curPrio;

  always_comb begin
    bestId   = '0;
    bestPrio = '0;
    curPrio  = '0;
    for (int s = 1; s <= NUM_SRC; s++) begin
      curPrio = prioFlat[(s-1)*PRIO_W +: PRIO_W];
      if (req[s] && (curPrio > thr) && (curPrio > bestPrio)) begin
        bestId   = ID_W'(s);
        bestPrio = curPrio;
      end
    end
  end
endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int NUM_CTX  = 2,
  parameter int PRIO_W   = 3,
  parameter int EDGE_MAX = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_SRC:1]  srcIrq,
  input  ctlStrobeT         stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] regRdata,
  output logic [NUM_CTX-1:0] ctxIrq
);
  localparam int ID_W  = $clog2(NUM_SRC + 1);
  localparam int CTX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;

  logic [NUM_SRC*PRIO_W-1:0] prioFlat;
  logic [NUM_SRC:1]          edgeQ;
  logic [NUM_SRC:1]          queueQ;
  logic [CTX_W-1:0]          ownerQ [NUM_SRC+1];
  logic [NUM_SRC:1]          enQ    [NUM_CTX];
  logic [PRIO_W-1:0]         thrQ   [NUM_CTX];
  logic [NUM_SRC:1]          pendVec;
  logic [NUM_SRC:1]          actVec;
  logic [ID_W-1:0]           bestId [NUM_CTX];
  logic [ID_W-1:0]           selBest;
  logic [CTX_W-1:0]          selCtx;
  logic [DATA_W-1:0]         rdNext;

  assign selCtx = stb.idx[CTX_W-1:0];

  always_comb begin
    selBest = '0;
    for (int c = 0; c < NUM_CTX; c++)
      if (stb.idx == IDX_W'(c)) selBest = bestId[c];
  end

  // configuration and claim ownership
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prioFlat <= '0;
      edgeQ    <= '0;
      queueQ   <= '0;
      for (int s = 0; s <= NUM_SRC; s++) ownerQ[s] <= '0;
      for (int c = 0; c < NUM_CTX; c++) begin
        enQ[c]  <= '0;
        thrQ[c] <= '0;
      end
    end else begin
      for (int s = 1; s <= NUM_SRC; s++) begin
        if (stb.wrPrio && stb.idx == IDX_W'(s))
          prioFlat[(s-1)*PRIO_W +: PRIO_W] <= wrData[PRIO_W-1:0];
        if (stb.wrCfg && stb.idx == IDX_W'(s)) begin
          edgeQ[s]  <= wrData[0];
          queueQ[s] <= wrData[1];
        end
        if (stb.claim && selBest == ID_W'(s))
          ownerQ[s] <= selCtx;
      end
      for (int c = 0; c < NUM_CTX; c++) begin
        if (stb.wrEn && stb.idx == IDX_W'(c))  enQ[c]  <= wrData[NUM_SRC:1];
        if (stb.wrThr && stb.idx == IDX_W'(c)) thrQ[c] <= wrData[PRIO_W-1:0];
      end
    end
  end

  for (genvar s = 1; s <= NUM_SRC; s++) begin : g_src
    logic claimHit;
    logic completeHit;
    assign claimHit    = stb.claim && (selBest == ID_W'(s));
    assign completeHit = stb.complete && (wrData == DATA_W'(s)) && (ownerQ[s] == selCtx);

    irq_router_gateway #(.EDGE_MAX(EDGE_MAX)) u_gw (
      .clk         (clk),
      .rstN        (rstN),
      .irqIn       (srcIrq[s]),
      .isEdge      (edgeQ[s]),
      .queueMode   (queueQ[s]),
      .claimStb    (claimHit),
      .completeStb (completeHit),
      .pending     (pendVec[s]),
      .active      (actVec[s])
    );
  end

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    irq_router_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_arb (
      .req      (pendVec & enQ[c]),
      .prioFlat (prioFlat),
      .thr      (thrQ[c]),
      .bestId   (bestId[c])
    );
    assign ctxIrq[c] = bestId[c] != '0;
  end

  // read mux
  always_comb begin
    rdNext = '0;
    case (stb.rdKind)
      KIND_PRIO: for (int s = 1; s <= NUM_SRC; s++)
        if (stb.idx == IDX_W'(s)) rdNext[PRIO_W-1:0] = prioFlat[(s-1)*PRIO_W +: PRIO_W];
      KIND_CFG: for (int s = 1; s <= NUM_SRC; s++)
        if (stb.idx == IDX_W'(s)) rdNext[1:0] = {queueQ[s], edgeQ[s]};
      KIND_EN: for (int c = 0; c < NUM_CTX; c++)
        if (stb.idx == IDX_W'(c)) rdNext[NUM_SRC:1] = enQ[c];
      KIND_THR: for (int c = 0; c < NUM_CTX; c++)
        if (stb.idx == IDX_W'(c)) rdNext[PRIO_W-1:0] = thrQ[c];
      KIND_CLAIM: rdNext[ID_W-1:0] = selBest;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regRdata <= '0;
    else if (stb.rdEn) regRdata <= rdNext;
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC  = 8,
  parameter int NUM_CTX  = 2,
  parameter int PRIO_W   = 3,
  parameter int EDGE_MAX = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC:1]   srcIrq,
  input  logic               regWe,
  input  logic               regRe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic [NUM_CTX-1:0] ctxIrq
);
  ctlStrobeT stb;

  irq_router_ctrl #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX)) u_ctrl (
    .regWe   (regWe),
    .regRe   (regRe),
    .regAddr (regAddr),
    .stb     (stb)
  );

  irq_router_dp #(
    .NUM_SRC (NUM_SRC),
    .NUM_CTX (NUM_CTX),
    .PRIO_W  (PRIO_W),
    .EDGE_MAX(EDGE_MAX)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .srcIrq   (srcIrq),
    .stb      (stb),
    .wrData   (regWdata),
    .regRdata (regRdata),
    .ctxIrq   (ctxIrq)
  );
endmodule

// File: tb/irq_router_tb.sv
module irq_router_tb;
  localparam int N = 8;
  localparam int NC = 2;
  localparam int PW = 3;
  localparam int EMAX = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [N:1]    srcIrq = '0;
  logic          regWe = 1'b0;
  logic          regRe = 1'b0;
  logic [8:0]    regAddr = '0;
  logic [31:0]   regWdata = '0;
  logic [31:0]   regRdata;
  logic [NC-1:0] ctxIrq;

  irq_router #(.NUM_SRC(N), .NUM_CTX(NC), .PRIO_W(PW), .EDGE_MAX(EMAX)) u_dut (
    .clk(clk), .rstN(rstN), .srcIrq(srcIrq), .regWe(regWe), .regRe(regRe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .ctxIrq(ctxIrq)
  );

  int nChk = 0;
  int nBad = 0;
  string curReq = "R1";

  // reference model state
  int mPrio [1:N];
  bit mEdge [1:N];
  bit mQueue [1:N];
  bit mPend [1:N];
  bit mAct [1:N];
  bit mPrev [1:N];
  int mCnt [1:N];
  int mOwner [1:N];
  bit mEn [NC][1:N];
  int mThr [NC];
  int mRd = 0;

  task automatic check(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int bestOf(int c);
    int bp = 0;
    int bi = 0;
    for (int s = 1; s <= N; s++)
      if (mPend[s] && mEn[c][s] && mPrio[s] > mThr[c] && mPrio[s] > bp) begin
        bp = mPrio[s];
        bi = s;
      end
    return bi;
  endfunction

  task automatic step();
    int best [NC];
    int grp, idx, claimId, claimC, compId, compC;
    bit isRd, rise, cl, co, wasAct, wasPend;
    for (int c = 0; c < NC; c++) best[c] = bestOf(c);
    grp = int'(regAddr[8:6]);
    idx = int'(regAddr[5:0]);
    claimId = 0; claimC = -1; compId = 0; compC = -1;
    isRd = !regWe && regRe;
    if (regWe && grp == 4 && idx < NC) begin
      compC = idx;
      compId = int'(regWdata);
    end
    if (isRd) begin
      mRd = 0;
      if ((grp == 0 || grp == 1) && idx >= 1 && idx <= N)
        mRd = (grp == 0) ? mPrio[idx] : ((int'(mQueue[idx]) << 1) | int'(mEdge[idx]));
      else if (grp == 2 && idx < NC) begin
        for (int s = 1; s <= N; s++) if (mEn[idx][s]) mRd = mRd | (1 << s);
      end else if (grp == 3 && idx < NC) mRd = mThr[idx];
      else if (grp == 4 && idx < NC) begin
        claimC = idx;
        claimId = best[idx];
        mRd = claimId;
      end
    end
    for (int s = 1; s <= N; s++) begin
      rise = srcIrq[s] && !mPrev[s];
      cl = (claimId == s);
      co = (compC >= 0) && (compId == s) && (mOwner[s] == compC);
      wasAct = mAct[s];
      wasPend = mPend[s];
      if (cl) begin
        mPend[s] = 1'b0; mAct[s] = 1'b1; mOwner[s] = claimC;
      end else if (co && wasAct) begin
        mAct[s] = 1'b0;
      end else if (!wasAct && !wasPend) begin
        if (!mEdge[s]) mPend[s] = srcIrq[s];
        else if (rise) mPend[s] = 1'b1;
        else if (mCnt[s] > 0) begin mPend[s] = 1'b1; mCnt[s]--; end
      end
      if (mEdge[s] && mQueue[s] && rise && (wasAct || wasPend || cl) && mCnt[s] < EMAX) mCnt[s]++;
      mPrev[s] = srcIrq[s];
    end
    if (regWe) begin
      if (grp == 0 && idx >= 1 && idx <= N) mPrio[idx] = int'(regWdata[PW-1:0]);
      if (grp == 1 && idx >= 1 && idx <= N) begin
        mEdge[idx] = regWdata[0]; mQueue[idx] = regWdata[1];
      end
      if (grp == 2 && idx < NC) for (int s = 1; s <= N; s++) mEn[idx][s] = regWdata[s];
      if (grp == 3 && idx < NC) mThr[idx] = int'(regWdata[PW-1:0]);
    end
    @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < NC; c++) check(curReq, int'(ctxIrq[c]), int'(bestOf(c) != 0));
    if (isRd) check(curReq, int'(regRdata), mRd);
  endtask

  task automatic wr(int a, int d);
    regWe = 1'b1; regAddr = 9'(a); regWdata = 32'(d);
    step();
    regWe = 1'b0;
  endtask

  task automatic rd(int a);
    regRe = 1'b1; regAddr = 9'(a);
    step();
    regRe = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulse(int s);
    srcIrq[s] = 1'b1; step();
    srcIrq[s] = 1'b0; step();
  endtask

  initial begin
    #(20 * 150000);
    nChk++; nBad++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    int seed;
    seed = int'($urandom(32'd4242));
    for (int s = 1; s <= N; s++) begin
      mPrio[s] = 0; mEdge[s] = 0; mQueue[s] = 0; mPend[s] = 0;
      mAct[s] = 0; mPrev[s] = 0; mCnt[s] = 0; mOwner[s] = 0;
    end
    for (int c = 0; c < NC; c++) begin
      mThr[c] = 0;
      for (int s = 1; s <= N; s++) mEn[c][s] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    curReq = "R1";
    check("R1", int'(ctxIrq), 0);
    rd(9'h003); check("R1", int'(regRdata), 0);
    rd(9'h043); check("R1", int'(regRdata), 0);
    rd(9'h080); check("R1", int'(regRdata), 0);
    rd(9'h0C1); check("R1", int'(regRdata), 0);
    rd(9'h100); check("R1", int'(regRdata), 0);

    // R11: readback and unmapped
    curReq = "R11";
    wr(9'h005, 6); rd(9'h005); check("R11", int'(regRdata), 6);
    wr(9'h045, 3); rd(9'h045); check("R11", int'(regRdata), 3);
    wr(9'h080, 9'h1FE); rd(9'h080); check("R11", int'(regRdata), 32'h1FE);
    wr(9'h0C1, 2); rd(9'h0C1); check("R11", int'(regRdata), 2);
    rd(9'h150); check("R11", int'(regRdata), 0);
    wr(9'h045, 0); wr(9'h005, 0); wr(9'h0C1, 0);

    // R2: enable gating
    curReq = "R2";
    wr(9'h080, 32'h004); wr(9'h081, 0); wr(9'h002, 3);
    srcIrq[2] = 1'b1; step();
    check("R2", int'(ctxIrq[0]), 1);
    check("R2", int'(ctxIrq[1]), 0);
    rd(9'h101); check("R2", int'(regRdata), 0);

    // R3: threshold
    curReq = "R3";
    wr(9'h0C0, 3); check("R3", int'(ctxIrq[0]), 0);
    wr(9'h0C0, 2); check("R3", int'(ctxIrq[0]), 1);
    wr(9'h0C0, 0); wr(9'h002, 0); check("R3", int'(ctxIrq[0]), 0);
    srcIrq[2] = 1'b0; wr(9'h002, 3); idle(1);

    // R4 / R5 / R6 / R7: level sources 4 and 6
    curReq = "R4";
    wr(9'h080, 32'h0D0); wr(9'h004, 5); wr(9'h006, 5); wr(9'h007, 6);
    srcIrq[4] = 1'b1; srcIrq[6] = 1'b1; step();
    rd(9'h100); check("R4", int'(regRdata), 4);
    curReq = "R6";
    wr(9'h101, 4); idle(2);
    rd(9'h100); check("R6", int'(regRdata), 6);
    curReq = "R7";
    wr(9'h100, 4); idle(1);
    rd(9'h100); check("R7", int'(regRdata), 4);
    srcIrq[7] = 1'b1; step();
    curReq = "R4";
    rd(9'h100); check("R4", int'(regRdata), 7);
    curReq = "R5";
    rd(9'h100); check("R5", int'(regRdata), 0);
    check("R5", int'(ctxIrq[0]), 0);
    srcIrq[4] = 1'b0; srcIrq[6] = 1'b0; srcIrq[7] = 1'b0;
    wr(9'h100, 4); wr(9'h100, 6); wr(9'h100, 7); idle(2);
    rd(9'h100); check("R7", int'(regRdata), 0);

    // R9: edge queue, source 1
    curReq = "R9";
    wr(9'h080, 32'h002); wr(9'h001, 4); wr(9'h041, 3);
    pulse(1);
    rd(9'h100); check("R9", int'(regRdata), 1);
    pulse(1); pulse(1); pulse(1);
    check("R9", int'(ctxIrq[0]), 0);
    wr(9'h100, 1); idle(1);
    check("R9", int'(ctxIrq[0]), 1);
    rd(9'h100); check("R9", int'(regRdata), 1);
    wr(9'h100, 1); idle(1);
    rd(9'h100); check("R9", int'(regRdata), 1);
    wr(9'h100, 1); idle(2);
    rd(9'h100); check("R9", int'(regRdata), 0);

    // R10: edge drop
    curReq = "R10";
    wr(9'h041, 1);
    pulse(1);
    rd(9'h100); check("R10", int'(regRdata), 1);
    pulse(1); pulse(1);
    wr(9'h100, 1); idle(2);
    check("R10", int'(ctxIrq[0]), 0);
    rd(9'h100); check("R10", int'(regRdata), 0);

    // R8: held-high edge source does not re-trigger
    curReq = "R8";
    srcIrq[1] = 1'b1; step();
    rd(9'h100); check("R8", int'(regRdata), 1);
    wr(9'h100, 1); idle(2);
    rd(9'h100); check("R8", int'(regRdata), 0);
    srcIrq[1] = 1'b0; step();

    // random phase against the model
    curReq = "R4";
    for (int s = 1; s <= N; s++) wr(s, int'($urandom_range(0, 7)));
    wr(9'h080, 32'h1FE); wr(9'h081, 32'h1FE);
    for (int i = 0; i < 4000; i++) begin
      int op, k, c;
      op = int'($urandom_range(0, 99));
      if ($urandom_range(0, 2) == 0) begin
        k = int'($urandom_range(1, N));
        srcIrq[k] = ~srcIrq[k];
      end
      c = int'($urandom_range(0, NC - 1));
      k = int'($urandom_range(1, N));
      if (op < 6) wr(k, int'($urandom_range(0, 7)));
      else if (op < 12) wr(9'h040 + k, int'($urandom_range(0, 3)));
      else if (op < 15) wr(9'h080 + c, int'($urandom) & 32'h1FE);
      else if (op < 18) wr(9'h0C0 + c, int'($urandom_range(0, 3)));
      else if (op < 42) rd(9'h100 + c);
      else if (op < 66) begin
        if (mAct[k] && $urandom_range(0, 3) != 0) c = mOwner[k];
        wr(9'h100 + c, k);
      end else if (op < 72) rd(int'($urandom_range(0, 4)) * 64 + int'($urandom_range(0, 9)));
      else step();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule